// File: doc/BRIEF.md
# Two-Wire Serial Client Register Port

This block lets a host on a two-wire serial bus (SMBus or I2C signalling) read and write a small register file that lives outside the block. Both bus lines are sampled in the system clock domain through two-flop synchronizers, and their edges are taken from the synchronized samples. Data is only ever driven onto SDA through an active-high pull-down enable. The block has no SCL output, so it can never stretch the clock, and it accepts any clock stretching by the host.

The host addresses the client with a 7-bit address. Six of its bits are a fixed parameter and the lowest bit comes from a strap input. In a write transfer, the first data byte sets an internal register pointer and every later byte is written to the register the pointer selects. In a read transfer, bytes are returned from the pointer onward. The pointer steps after every data byte in both directions and persists across transfers.

Top module: `tw_reg_client`

## Requirements
- R1: A falling SDA while SCL is high (START) restarts address reception from bit zero in any state, so a repeated START without a STOP begins a new transfer.
- R2: A rising SDA while SCL is high (STOP) returns the client to idle with SDA released; after reset SDA is released and no register write is strobed.
- R3: The first byte after START is compared MSB first against the 7-bit address {ADDR_PREFIX, addrSel}, with the default prefix 010100, giving 0101000 or 0101001. Bit 0 of the byte is the direction (0 = host writes, 1 = host reads). On a match the client pulls SDA low for the ninth clock.
- R4: On an address mismatch the client acknowledges nothing and writes nothing until the next START or STOP.
- R5: In a write transfer the first data byte is acknowledged, and its low PTR_W bits load the register pointer.
- R6: Each later write byte is acknowledged and strobes regWrEn for one cycle with regAddr equal to the pointer. The pointer then steps by one and wraps from NUM_REGS-1 to 0.
- R7: In a read transfer the client shifts out regRdData at the current pointer, MSB first, and steps the pointer after each byte.
- R8: If the host acknowledges a read byte (SDA low in the ninth clock), the next byte follows. A NACK makes the client release SDA and stay silent until START or STOP.
- R9: sdaOe changes only while SCL is low.
- R10: The pointer persists across a STOP, so a read without a new pointer byte continues from the last position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as sampled (asynchronous) |
| sdaIn | input | 1 | Bus data line as sampled (asynchronous) |
| addrSel | input | 1 | Strap selecting the lowest address bit |
| sdaOe | output | 1 | 1 pulls SDA low, 0 releases it |
| regAddr | output | PTR_W | Register pointer, used as the read and write address |
| regWrEn | output | 1 | One-cycle write strobe |
| regWrData | output | 8 | Byte to write |
| regRdData | input | 8 | Combinational read data at regAddr |

## Verification
The register write and the pointer step happen on the same clock edge, at the SCL fall that ends a received byte. This is provoked with block writes that sweep every register from pointer zero, plus one block write that starts at the last register so the step wraps in the middle of the transfer. The sweep is judged by reading everything back through block reads with a repeated START: each byte must sit at the pointer it was written to, not at the stepped pointer. The bench also compares every read byte against values it computes arithmetically.

// File: rtl/tw_reg_pkg.sv
package tw_reg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WBYTE, ST_WACK, ST_RBYTE, ST_RACK, ST_IGNORE
  } twState_e;

  typedef struct packed {
    logic cntClr;
    logic rxShift;
    logic txLoad;
    logic txShift;
    logic ptrLoad;
    logic ptrInc;
    logic wrStb;
  } twStrobe_t;
endpackage

// File: rtl/tw_reg_dp.sv
module tw_reg_dp
  import tw_reg_pkg::*;
#(
  parameter int NUM_REGS = 16,
  localparam int PTR_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  twStrobe_t        stb,
  input  logic             sdaBit,
  input  logic [7:0]       regRdData,
  output logic [7:0]       rxByte,
  output logic [3:0]       bitCnt,
  output logic             txBit,
  output logic [PTR_W-1:0] regAddr,
  output logic             regWrEn,
  output logic [7:0]       regWrData
);
  localparam logic [PTR_W-1:0] LAST_REG = PTR_W'(NUM_REGS - 1);

  logic [7:0]       shReg;
  logic [PTR_W-1:0] ptr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      bitCnt <= '0;
      ptr    <= '0;
    end else begin
      if (stb.txLoad) begin
        shReg  <= regRdData;
        bitCnt <= '0;
      end else if (stb.rxShift) begin
        shReg  <= {shReg[6:0], sdaBit};
        bitCnt <= bitCnt + 4'd1;
      end else if (stb.txShift) begin
        shReg  <= {shReg[6:0], 1'b0};
        bitCnt <= bitCnt + 4'd1;
      end else if (stb.cntClr) begin
        bitCnt <= '0;
      end
      if (stb.ptrLoad) ptr <= shReg[PTR_W-1:0];
      else if (stb.ptrInc) ptr <= (ptr == LAST_REG) ? '0 : ptr + PTR_W'(1);
    end
  end

  assign rxByte    = shReg;
  assign txBit     = shReg[7];
  assign regAddr   = ptr;
  assign regWrEn   = stb.wrStb;
  assign regWrData = shReg;

  // R6
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ptrInc && !stb.ptrLoad) |=>
      regAddr == (($past(regAddr) == LAST_REG) ? '0 : $past(regAddr) + PTR_W'(1)));
endmodule

// File: rtl/tw_reg_ctrl.sv
module tw_reg_ctrl
  import tw_reg_pkg::*;
#(
  parameter logic [5:0] ADDR_PREFIX = 6'b010100
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       addrSel,
  input  logic [7:0] rxByte,
  input  logic [3:0] bitCnt,
  input  logic       txBit,
  output twStrobe_t  stb,
  output logic       sdaBit,
  output logic       sdaOe
);
  logic [1:0] sclSync, sdaSync;
  logic       sclPrev, sdaPrev, sclS, sdaS;
  logic       startDet, stopDet, sclRise, sclFall;
  twState_e   state, nState;
  logic       isRead, readNext, firstByte, firstNext, hostAck, ackNext, oeNext;
  logic       addrHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclSync[1];
      sdaPrev <= sdaSync[1];
    end
  end

  assign sclS     = sclSync[1];
  assign sdaS     = sdaSync[1];
  assign sdaBit   = sdaS;
  assign startDet = sclS && sclPrev && sdaPrev && !sdaS;
  assign stopDet  = sclS && sclPrev && !sdaPrev && sdaS;
  assign sclRise  = sclS && !sclPrev;
  assign sclFall  = !sclS && sclPrev;
  assign addrHit  = (rxByte[7:1] == {ADDR_PREFIX, addrSel});

  always_comb begin
    stb       = '0;
    nState    = state;
    oeNext    = sdaOe;
    readNext  = isRead;
    firstNext = firstByte;
    ackNext   = hostAck;
    if (stopDet) begin
      nState = ST_IDLE;
      oeNext = 1'b0;
    end else if (startDet) begin
      nState     = ST_ADDR;
      stb.cntClr = 1'b1;
      oeNext     = 1'b0;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (sclRise && bitCnt < 4'd8) stb.rxShift = 1'b1;
          if (sclFall && bitCnt == 4'd8) begin
            if (addrHit) begin
              oeNext   = 1'b1;
              readNext = rxByte[0];
              nState   = ST_AACK;
            end else begin
              nState = ST_IGNORE;
            end
          end
        end
        ST_AACK: if (sclFall) begin
          oeNext = 1'b0;
          if (isRead) begin
            stb.txLoad = 1'b1;
            nState     = ST_RBYTE;
          end else begin
            stb.cntClr = 1'b1;
            firstNext  = 1'b1;
            nState     = ST_WBYTE;
          end
        end
        ST_WBYTE: begin
          if (sclRise && bitCnt < 4'd8) stb.rxShift = 1'b1;
          if (sclFall && bitCnt == 4'd8) begin
            oeNext    = 1'b1;
            firstNext = 1'b0;
            nState    = ST_WACK;
            if (firstByte) stb.ptrLoad = 1'b1;
            else begin
              stb.wrStb  = 1'b1;
              stb.ptrInc = 1'b1;
            end
          end
        end
        ST_WACK: if (sclFall) begin
          oeNext     = 1'b0;
          stb.cntClr = 1'b1;
          nState     = ST_WBYTE;
        end
        ST_RBYTE: begin
          if (!sclS) oeNext = !txBit;
          if (sclFall) begin
            if (bitCnt == 4'd7) begin
              oeNext     = 1'b0;
              stb.ptrInc = 1'b1;
              nState     = ST_RACK;
            end else begin
              stb.txShift = 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (sclRise) ackNext = !sdaS;
          if (sclFall) begin
            if (hostAck) begin
              stb.txLoad = 1'b1;
              nState     = ST_RBYTE;
            end else begin
              nState = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      sdaOe     <= 1'b0;
      isRead    <= 1'b0;
      firstByte <= 1'b0;
      hostAck   <= 1'b0;
    end else begin
      state     <= nState;
      sdaOe     <= oeNext;
      isRead    <= readNext;
      firstByte <= firstNext;
      hostAck   <= ackNext;
    end
  end

  // R2
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (state == ST_IDLE && !sdaOe));
  // R1
  start_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (state == ST_ADDR && bitCnt == 4'd0));
  // R9
  sda_lowscl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclS);
  // R4
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IGNORE && !startDet) |-> (!sdaOe && stb == '0));
  // R6
  write_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrStb |-> !isRead);
endmodule

// File: rtl/tw_reg_client.sv
module tw_reg_client
  import tw_reg_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter logic [5:0] ADDR_PREFIX = 6'b010100,
  localparam int PTR_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic             addrSel,
  output logic             sdaOe,
  output logic [PTR_W-1:0] regAddr,
  output logic             regWrEn,
  output logic [7:0]       regWrData,
  input  logic [7:0]       regRdData
);
  twStrobe_t  stb;
  logic [7:0] rxByte;
  logic [3:0] bitCnt;
  logic       txBit, sdaBit;

  tw_reg_ctrl #(.ADDR_PREFIX(ADDR_PREFIX)) uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .addrSel(addrSel),
    .rxByte(rxByte), .bitCnt(bitCnt), .txBit(txBit), .stb(stb),
    .sdaBit(sdaBit), .sdaOe(sdaOe)
  );

  tw_reg_dp #(.NUM_REGS(NUM_REGS)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaBit(sdaBit), .regRdData(regRdData),
    .rxByte(rxByte), .bitCnt(bitCnt), .txBit(txBit), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData)
  );
endmodule

// File: tb/sim_tw_reg_client.sv
module sim_tw_reg_client;
  localparam int Q = 8;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0, hostScl = 1'b1, hostSda = 1'b1, addrSel = 1'b0;
  logic sdaOe, regWrEn;
  logic [3:0] regAddr;
  logic [7:0] regWrData, regRdData;
  logic [7:0] mem [16];
  logic busSda;
  int checks = 0, fails = 0, sclViol = 0;
  logic oePrev = 1'b0;
  logic finished = 1'b0;

  assign busSda    = hostSda & ~sdaOe;
  assign regRdData = mem[regAddr];

  tw_reg_client u0 (
    .clk(clk), .rstN(rstN), .sclIn(hostScl), .sdaIn(busSda), .addrSel(addrSel),
    .sdaOe(sdaOe), .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData)
  );

  always @(posedge clk) if (regWrEn) mem[regAddr] <= regWrData;

  // SDA enable must only move while the host holds SCL low
  always @(negedge clk) begin
    if (rstN && sdaOe !== oePrev && hostScl) sclViol++;
    oePrev <= sdaOe;
  end

  function automatic logic [7:0] val(int i, int s);
    return 8'((i * 37 + s * 91 + 13) & 255);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    hostSda = 1'b1; tick(Q); hostScl = 1'b1; tick(Q);
    hostSda = 1'b0; tick(Q); hostScl = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    hostSda = 1'b0; tick(Q); hostScl = 1'b1; tick(Q); hostSda = 1'b1; tick(Q);
  endtask

  task automatic bitOut(logic b);
    tick(Q); hostSda = b; tick(Q); hostScl = 1'b1; tick(2 * Q); hostScl = 1'b0;
  endtask

  task automatic bitIn(output logic b);
    hostSda = 1'b1; tick(2 * Q); hostScl = 1'b1; tick(Q); b = busSda; tick(Q);
    hostScl = 1'b0;
  endtask

  task automatic sendByte(logic [7:0] d, output logic nack);
    for (int k = 7; k >= 0; k--) bitOut(d[k]);
    bitIn(nack);
  endtask

  task automatic recvByte(logic ack, output logic [7:0] d);
    for (int k = 7; k >= 0; k--) bitIn(d[k]);
    bitOut(~ack);
  endtask

  function automatic logic [7:0] addrByte(logic s, logic rd);
    return {6'b010100, s, rd};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic nk;
    logic [7:0] d;
    for (int i = 0; i < 16; i++) mem[i] = 8'hA0 + 8'(i);
    tick(5);
    rstN = 1'b1;
    tick(5);
    chk("R2 reset sdaOe", {7'd0, sdaOe}, 8'd0);
    chk("R2 reset regWrEn", {7'd0, regWrEn}, 8'd0);

    for (int s = 0; s < 2; s++) begin
      addrSel = s[0];
      // block write sweep from pointer 0
      busStart();
      sendByte(addrByte(s[0], 1'b0), nk); chk("R3 write address ack", {7'd0, nk}, 8'd0);
      sendByte(8'd0, nk); chk("R5 pointer byte ack", {7'd0, nk}, 8'd0);
      for (int i = 0; i < 16; i++) begin
        sendByte(val(i, s), nk); chk("R6 data ack", {7'd0, nk}, 8'd0);
      end
      busStop();
      for (int i = 0; i < 16; i++) chk("R6 stored byte", mem[i], val(i, s));
      // pointer set, repeated START, block read
      busStart();
      sendByte(addrByte(s[0], 1'b0), nk);
      sendByte(8'd0, nk);
      busStart();
      sendByte(addrByte(s[0], 1'b1), nk); chk("R1 repeated start read ack", {7'd0, nk}, 8'd0);
      for (int i = 0; i < 16; i++) begin
        recvByte(i != 15, d); chk("R7 R8 block read", d, val(i, s));
      end
      busStop();
      // other strap value must be ignored
      busStart();
      sendByte(addrByte(~s[0], 1'b0), nk); chk("R4 foreign address nack", {7'd0, nk}, 8'd1);
      sendByte(8'd3, nk); chk("R4 ignored byte nack", {7'd0, nk}, 8'd1);
      sendByte(8'h55, nk);
      busStop();
      chk("R4 register untouched", mem[3], val(3, s));
    end

    // pointer wrap within one write
    busStart();
    sendByte(addrByte(1'b1, 1'b0), nk);
    sendByte(8'd15, nk);
    sendByte(8'h11, nk);
    sendByte(8'h22, nk);
    busStop();
    chk("R6 last register", mem[15], 8'h11);
    chk("R6 wrapped to zero", mem[0], 8'h22);

    // pointer persists across STOP
    busStart();
    sendByte(addrByte(1'b1, 1'b0), nk);
    sendByte(8'd5, nk);
    busStop();
    busStart();
    sendByte(addrByte(1'b1, 1'b1), nk);
    recvByte(1'b0, d); chk("R10 read after stop", d, val(5, 1));
    recvByte(1'b0, d); chk("R8 released after nack", d, 8'hFF);
    busStop();
    busStart();
    sendByte(addrByte(1'b1, 1'b1), nk);
    recvByte(1'b0, d); chk("R7 pointer stepped", d, val(6, 1));
    busStop();
    chk("R2 idle after stop", {7'd0, sdaOe}, 8'd0);

    chk("R9 sda moves only with scl low", 8'(sclViol), 8'd0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule